// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for single word and byte load/store operations and the value that the base register should take afterwards. Each request supplies a base value, the current program counter, a sign-extended immediate or a register offset, a shift direction and amount for the register offset, an add/subtract selector, an indexing mode and a PC-relative select. It returns the effective address, the updated base value, a writeback enable and a byte-lane mask. It also returns the load/store and byte/word flags decoded from the transfer kind.

The block sits between operand read and the memory port of a pipeline. Decode drives the controls, and the register file supplies the operand values. The result is registered, so a request presented in one cycle is answered in the next. When no request is presented, the outputs hold their last values and the response valid drops.

Top module: `ls_agen`

## Requirements
- R1: The outputs register the request. `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low. When no request is presented, `eff_addr`, `new_base`, `wb_en`, `lane_sel`, `is_load` and `is_byte` keep their previous values.
- R2: Plain pre-indexed mode (`idx_mode` 2'b00, or the spare code 2'b11) gives effective address = base + offset. It also gives `new_base` = base and `wb_en` = 0.
- R3: Pre-indexed writeback mode (`idx_mode` 2'b01) gives effective address = base + offset. It also gives `new_base` equal to that address and `wb_en` = 1.
- R4: Post-indexed mode (`idx_mode` 2'b10) gives effective address = base unchanged. It also gives `new_base` = base + offset and `wb_en` = 1.
- R5: With `off_is_reg` = 0, the offset is `imm_off` taken as a 13-bit two's complement value and sign-extended to 32 bits. It is always added, and `off_sub` has no effect.
- R6: With `off_is_reg` = 1, `reg_off` is shifted by `shift_amt` (0..31), zero-filled. `shift_dir` = 0 shifts left and `shift_dir` = 1 shifts right. An amount of 0 passes the value through unchanged in both directions.
- R7: With `off_is_reg` = 1, `off_sub` = 1 subtracts the shifted register offset from the base, and `off_sub` = 0 adds it.
- R8: With `pc_rel` = 1, the base is `pc_val` and the offset is the immediate. The form is plain pre-indexed, with `new_base` = `base_val` and `wb_en` = 0. Both `idx_mode` and `off_is_reg` are ignored.
- R9: For `xfer_kind`, bit 0 = 1 means load and bit 1 = 1 means byte. The codes are 00 store word, 01 load word, 10 store byte and 11 load byte. They appear on `is_load` and `is_byte`.
- R10: For a byte transfer, `lane_sel` is one-hot, with bit number `eff_addr[1:0]` set. For a word transfer, `lane_sel` is 4'b1111.
- R11: All address arithmetic is 32-bit and wraps modulo 2^32.
- R12: While in reset, and right after reset, `rsp_valid`, `wb_en`, `eff_addr`, `new_base`, `lane_sel`, `is_load` and `is_byte` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe; the controls are sampled when high |
| base_val | input | 32 | Base register value |
| pc_val | input | 32 | Current program counter |
| imm_off | input | 13 | Signed immediate offset |
| reg_off | input | 32 | Offset register value |
| off_is_reg | input | 1 | 1 selects the register offset, 0 selects the immediate |
| shift_dir | input | 1 | Register offset shift: 0 left, 1 right |
| shift_amt | input | 5 | Register offset shift amount |
| off_sub | input | 1 | 1 subtracts the register offset |
| idx_mode | input | 2 | 00 pre, 01 pre with writeback, 10 post, 11 pre |
| pc_rel | input | 1 | PC-relative addressing |
| xfer_kind | input | 2 | Transfer kind (bit0 load, bit1 byte) |
| rsp_valid | output | 1 | Result valid |
| eff_addr | output | 32 | Effective address |
| new_base | output | 32 | Updated base register value |
| wb_en | output | 1 | Base register writeback enable |
| lane_sel | output | 4 | Byte-lane enables |
| is_load | output | 1 | Transfer is a load |
| is_byte | output | 1 | Transfer is a byte |

## Verification
Every result is due exactly one clock edge after its request: the inputs are sampled at a rising edge, and all outputs change at that same edge. The bench drives a request at a falling edge and reads the outputs at the next falling edge. At that moment it checks the previous request before it applies the next one, so the sweep issues one request per cycle. Holding behaviour is checked by dropping the request strobe and reading one falling edge later. The reset state is read after the internal two-stage release has completed.

// File: rtl/ls_agen_pkg.sv
package ls_agen_pkg;

  typedef enum logic [1:0] {
    IDX_PRE     = 2'b00,
    IDX_PRE_WB  = 2'b01,
    IDX_POST    = 2'b10,
    IDX_PRE_ALT = 2'b11
  } idx_mode_e;

  typedef enum logic {
    SH_LEFT  = 1'b0,
    SH_RIGHT = 1'b1
  } shift_dir_e;

  typedef struct packed {
    logic is_byte;
    logic is_load;
  } xfer_t;

  function automatic xfer_t decode_xfer(input logic [1:0] kind);
    xfer_t x;
    x.is_load = kind[0];
    x.is_byte = kind[1];
    return x;
  endfunction

endpackage

// File: rtl/lsag_offset_unit.sv
module lsag_offset_unit
  import ls_agen_pkg::*;
#(
  parameter int AW      = 32,
  parameter int IMM_W   = 13,
  parameter int SHAMT_W = 5
) (
  input  logic [IMM_W-1:0]   imm_off,
  input  logic [AW-1:0]      reg_off,
  input  logic               use_reg,
  input  shift_dir_e         dir,
  input  logic [SHAMT_W-1:0] amt,
  input  logic               sub,
  output logic [AW-1:0]      addend
);

  localparam int EXT_W = AW - IMM_W;

  logic [AW-1:0] stg [0:SHAMT_W];
  logic [AW-1:0] imm_ext;
  logic [AW-1:0] reg_term;

  assign stg[0] = reg_off;

  // logarithmic shifter: stage s moves by 2**s when amount bit s is set
  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    logic [AW-1:0] moved;
    assign moved = (dir == SH_RIGHT) ? (stg[s] >> SH) : (stg[s] << SH);
    assign stg[s+1] = amt[s] ? moved : stg[s];
  end

  assign imm_ext  = {{EXT_W{imm_off[IMM_W-1]}}, imm_off};
  assign reg_term = sub ? (~stg[SHAMT_W] + {{(AW-1){1'b0}}, 1'b1}) : stg[SHAMT_W];

  always_comb begin
    if (use_reg) addend = reg_term;
    else         addend = imm_ext;
  end

endmodule

// File: rtl/lsag_index_unit.sv
module lsag_index_unit
  import ls_agen_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] pc_val,
  input  logic [AW-1:0] addend,
  input  idx_mode_e     mode,
  input  logic          pc_rel,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] nb,
  output logic          wb
);

  logic [AW-1:0] src;
  logic [AW-1:0] sum;

  assign src = pc_rel ? pc_val : base_val;
  assign sum = src + addend;

  always_comb begin
    ea = sum;
    nb = base_val;
    wb = 1'b0;
    if (!pc_rel) begin
      unique case (mode)
        IDX_PRE_WB: begin
          ea = sum;
          nb = sum;
          wb = 1'b1;
        end
        IDX_POST: begin
          ea = base_val;
          nb = sum;
          wb = 1'b1;
        end
        default: begin
          ea = sum;
          nb = base_val;
          wb = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/lsag_lane_dec.sv
module lsag_lane_dec #(
  parameter int LANES = 4
) (
  input  logic [$clog2(LANES)-1:0] addr_lo,
  input  logic                     is_byte,
  output logic [LANES-1:0]         lanes
);

  localparam int LIDX_W = $clog2(LANES);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lanes[i] = is_byte ? (addr_lo == LIDX_W'(i)) : 1'b1;
  end

endmodule

// File: rtl/ls_agen.sv
module ls_agen
  import ls_agen_pkg::*;
#(
  parameter int AW      = 32,
  parameter int IMM_W   = 13,
  parameter int SHAMT_W = 5,
  parameter int LANES   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [AW-1:0]      base_val,
  input  logic [AW-1:0]      pc_val,
  input  logic [IMM_W-1:0]   imm_off,
  input  logic [AW-1:0]      reg_off,
  input  logic               off_is_reg,
  input  logic               shift_dir,
  input  logic [SHAMT_W-1:0] shift_amt,
  input  logic               off_sub,
  input  logic [1:0]         idx_mode,
  input  logic               pc_rel,
  input  logic [1:0]         xfer_kind,
  output logic               rsp_valid,
  output logic [AW-1:0]      eff_addr,
  output logic [AW-1:0]      new_base,
  output logic               wb_en,
  output logic [LANES-1:0]   lane_sel,
  output logic               is_load,
  output logic               is_byte
);

  localparam int LIDX_W = $clog2(LANES);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // combinational datapath
  logic [AW-1:0]    addend;
  logic [AW-1:0]    ea_c;
  logic [AW-1:0]    nb_c;
  logic             wb_c;
  logic [LANES-1:0] lanes_c;
  xfer_t            xfer_c;

  assign xfer_c = decode_xfer(xfer_kind);

  lsag_offset_unit #(
    .AW(AW), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)
  ) u_off (
    .imm_off (imm_off),
    .reg_off (reg_off),
    .use_reg (off_is_reg && !pc_rel),
    .dir     (shift_dir_e'(shift_dir)),
    .amt     (shift_amt),
    .sub     (off_sub),
    .addend  (addend)
  );

  lsag_index_unit #(.AW(AW)) u_idx (
    .base_val (base_val),
    .pc_val   (pc_val),
    .addend   (addend),
    .mode     (idx_mode_e'(idx_mode)),
    .pc_rel   (pc_rel),
    .ea       (ea_c),
    .nb       (nb_c),
    .wb       (wb_c)
  );

  lsag_lane_dec #(.LANES(LANES)) u_lane (
    .addr_lo (ea_c[LIDX_W-1:0]),
    .is_byte (xfer_c.is_byte),
    .lanes   (lanes_c)
  );

  // next-state
  logic             ld_en;
  logic             vld_d;
  logic [AW-1:0]    ea_d;
  logic [AW-1:0]    nb_d;
  logic             wb_d;
  logic [LANES-1:0] lanes_d;
  logic             load_d;
  logic             byte_d;

  assign ld_en = req_valid;

  always_comb begin
    vld_d   = req_valid;
    ea_d    = eff_addr;
    nb_d    = new_base;
    wb_d    = wb_en;
    lanes_d = lane_sel;
    load_d  = is_load;
    byte_d  = is_byte;
    if (ld_en) begin
      ea_d    = ea_c;
      nb_d    = nb_c;
      wb_d    = wb_c;
      lanes_d = lanes_c;
      load_d  = xfer_c.is_load;
      byte_d  = xfer_c.is_byte;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      eff_addr  <= '0;
      new_base  <= '0;
      wb_en     <= 1'b0;
      lane_sel  <= '0;
      is_load   <= 1'b0;
      is_byte   <= 1'b0;
    end else begin
      rsp_valid <= vld_d;
      eff_addr  <= ea_d;
      new_base  <= nb_d;
      wb_en     <= wb_d;
      lane_sel  <= lanes_d;
      is_load   <= load_d;
      is_byte   <= byte_d;
    end
  end

endmodule

// File: rtl/ls_agen_chk.sv
module ls_agen_chk #(
  parameter int AW    = 32,
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             req_valid,
  input logic             pc_rel,
  input logic [1:0]       idx_mode,
  input logic [AW-1:0]    base_val,
  input logic [1:0]       xfer_kind,
  input logic             rsp_valid,
  input logic [AW-1:0]    eff_addr,
  input logic [AW-1:0]    new_base,
  input logic             wb_en,
  input logic [LANES-1:0] lane_sel,
  input logic             is_load,
  input logic             is_byte
);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> (!rsp_valid && $stable(eff_addr) && $stable(new_base))); // R1

  AST_PRE_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !pc_rel && idx_mode == 2'b00) |=> (!wb_en && new_base == $past(base_val))); // R2

  AST_PREWB_UPDATES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !pc_rel && idx_mode == 2'b01) |=> (wb_en && new_base == eff_addr)); // R3

  AST_POST_USES_BASE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !pc_rel && idx_mode == 2'b10) |=> (wb_en && eff_addr == $past(base_val))); // R4

  AST_PCREL_NO_WB: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && pc_rel) |=> (!wb_en && new_base == $past(base_val))); // R8

  AST_KIND_FLAGS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> (is_load == $past(xfer_kind[0]) && is_byte == $past(xfer_kind[1]))); // R9

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && is_byte) |-> ($countones(lane_sel) == 1)); // R10

  AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && !is_byte) |-> (lane_sel == {LANES{1'b1}})); // R10

endmodule

bind ls_agen ls_agen_chk #(.AW(AW), .LANES(LANES)) u_chk (.*);

// File: tb/ls_agen_tb_top.sv
module ls_agen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] base_val, pc_val, reg_off;
  logic [12:0] imm_off;
  logic        off_is_reg, shift_dir, off_sub, pc_rel;
  logic [4:0]  shift_amt;
  logic [1:0]  idx_mode, xfer_kind;
  logic        rsp_valid, wb_en, is_load, is_byte;
  logic [31:0] eff_addr, new_base;
  logic [3:0]  lane_sel;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ls_agen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .base_val(base_val), .pc_val(pc_val), .imm_off(imm_off), .reg_off(reg_off),
    .off_is_reg(off_is_reg), .shift_dir(shift_dir), .shift_amt(shift_amt),
    .off_sub(off_sub), .idx_mode(idx_mode), .pc_rel(pc_rel), .xfer_kind(xfer_kind),
    .rsp_valid(rsp_valid), .eff_addr(eff_addr), .new_base(new_base), .wb_en(wb_en),
    .lane_sel(lane_sel), .is_load(is_load), .is_byte(is_byte)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // Drives one request at a falling edge, checks it one falling edge later.
  task automatic run_req(input string tag, input logic [1:0] mode, input logic pcr,
                         input logic isreg, input logic sub, input logic dir,
                         input logic [4:0] amt, input logic [1:0] kind,
                         input logic [31:0] base, input logic [31:0] pc,
                         input logic [31:0] rv, input logic [12:0] imm);
    logic [31:0] off, src, sum, e_ea, e_nb, sh;
    logic        e_wb;
    logic [3:0]  e_ln;
    req_valid = 1'b1; idx_mode = mode; pc_rel = pcr; off_is_reg = isreg;
    off_sub = sub; shift_dir = dir; shift_amt = amt; xfer_kind = kind;
    base_val = base; pc_val = pc; reg_off = rv; imm_off = imm;
    sh = dir ? (rv >> amt) : (rv << amt);
    if (pcr || !isreg) off = {{19{imm[12]}}, imm};
    else               off = sub ? (32'd0 - sh) : sh;
    src = pcr ? pc : base;
    sum = src + off;
    if (pcr)              begin e_ea = sum;  e_nb = base; e_wb = 1'b0; end
    else if (mode == 2'b01) begin e_ea = sum;  e_nb = sum;  e_wb = 1'b1; end
    else if (mode == 2'b10) begin e_ea = base; e_nb = sum;  e_wb = 1'b1; end
    else                  begin e_ea = sum;  e_nb = base; e_wb = 1'b0; end
    e_ln = kind[1] ? (4'b0001 << e_ea[1:0]) : 4'b1111;
    @(negedge clk);
    chk({tag, " rsp_valid R1"}, {31'd0, rsp_valid}, 32'd1);
    chk({tag, " eff_addr"}, eff_addr, e_ea);
    chk({tag, " new_base"}, new_base, e_nb);
    chk({tag, " wb_en"}, {31'd0, wb_en}, {31'd0, e_wb});
    chk({tag, " lane_sel R10"}, {28'd0, lane_sel}, {28'd0, e_ln});
    chk({tag, " kind R9"}, {30'd0, is_byte, is_load}, {30'd0, kind});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] bases [4] = '{32'h0000_1000, 32'hFFFF_FFF0, 32'h8000_0003, 32'h1234_5679};
    logic [31:0] regs  [4] = '{32'h0000_0004, 32'h8000_0001, 32'hFFFF_FFFF, 32'h0F0F_1234};
    logic [12:0] imms  [4] = '{13'h0004, 13'h1FFC, 13'h0FFF, 13'h1000};
    string mtag;
    rst_n = 1'b0; req_valid = 1'b0; base_val = '0; pc_val = '0; reg_off = '0;
    imm_off = '0; off_is_reg = 1'b0; shift_dir = 1'b0; shift_amt = '0;
    off_sub = 1'b0; idx_mode = '0; pc_rel = 1'b0; xfer_kind = '0;
    repeat (3) @(negedge clk);
    // R12: state during reset
    chk("R12 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R12 eff_addr", eff_addr, 32'd0);
    chk("R12 new_base", new_base, 32'd0);
    chk("R12 wb_en/flags", {28'd0, wb_en, is_load, is_byte, 1'b0}, 32'd0);
    chk("R12 lane_sel", {28'd0, lane_sel}, 32'd0);

    // directed corner cases
    run_req("R5 imm negative, sub ignored", 2'b00, 0, 0, 1, 0, 5'd0, 2'b01,
            32'h0000_0100, 32'h0, 32'hDEAD_BEEF, 13'h1FF0);
    chk("R5 eff_addr", eff_addr, 32'h0000_00F0);
    run_req("R6 amt0 left", 2'b00, 0, 1, 0, 0, 5'd0, 2'b00,
            32'h0000_0010, 32'h0, 32'h8000_0001, 13'h0);
    chk("R6 amt0 left eff_addr", eff_addr, 32'h8000_0011);
    run_req("R6 amt0 right", 2'b00, 0, 1, 0, 1, 5'd0, 2'b00,
            32'h0000_0010, 32'h0, 32'h8000_0001, 13'h0);
    chk("R6 amt0 right eff_addr", eff_addr, 32'h8000_0011);
    run_req("R6 lsr31", 2'b00, 0, 1, 0, 1, 5'd31, 2'b00,
            32'h0000_0010, 32'h0, 32'h8000_0001, 13'h0);
    chk("R6 lsr31 eff_addr", eff_addr, 32'h0000_0011);
    run_req("R7 subtract lsl2", 2'b01, 0, 1, 1, 0, 5'd2, 2'b00,
            32'h0000_0100, 32'h0, 32'h0000_0004, 13'h0);
    chk("R7 eff_addr", eff_addr, 32'h0000_00F0);
    run_req("R11 wrap up", 2'b10, 0, 0, 0, 0, 5'd0, 2'b11,
            32'hFFFF_FFFE, 32'h0, 32'h0, 13'h0004);
    chk("R11 new_base", new_base, 32'h0000_0002);
    run_req("R8 pcrel ignores mode/reg", 2'b01, 1, 1, 1, 0, 5'd3, 2'b11,
            32'h0000_5555, 32'h0000_8000, 32'h0000_0FFF, 13'h1FFF);
    chk("R8 eff_addr", eff_addr, 32'h0000_7FFF);
    chk("R8 wb_en", {31'd0, wb_en}, 32'd0);

    // R1: with no request the outputs hold and valid drops
    req_valid = 1'b0; base_val = 32'h1357_9BDF; idx_mode = 2'b01; xfer_kind = 2'b00;
    @(negedge clk);
    chk("R1 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 idle eff_addr hold", eff_addr, 32'h0000_7FFF);
    chk("R1 idle new_base hold", new_base, 32'h0000_5555);
    chk("R1 idle lane hold", {28'd0, lane_sel}, 32'h0000_0008);
    chk("R1 idle kind hold", {30'd0, is_byte, is_load}, 32'd3);

    // sweep: mode x pc_rel x source x sub x dir x amount x kind x pattern
    for (int m = 0; m < 4; m++)
      for (int pr = 0; pr < 2; pr++)
        for (int ir = 0; ir < 2; ir++)
          for (int sb = 0; sb < 2; sb++)
            for (int dr = 0; dr < 2; dr++)
              for (int a = 0; a < 32; a++)
                for (int k = 0; k < 4; k++)
                  for (int p = 0; p < 4; p++) begin
                    if (pr != 0)      mtag = "R8";
                    else if (m == 1)  mtag = "R3";
                    else if (m == 2)  mtag = "R4";
                    else              mtag = "R2";
                    run_req($sformatf("%s sweep m%0d r%0d s%0d d%0d a%0d k%0d p%0d",
                                      mtag, m, ir, sb, dr, a, k, p),
                            2'(m), 1'(pr), 1'(ir), 1'(sb), 1'(dr), 5'(a), 2'(k),
                            bases[p], 32'h0000_8002 + 32'(p), regs[p], imms[p]);
                  end
    req_valid = 1'b0;
    @(negedge clk);
    chk("R1 final idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule